// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

A memory-mapped general-purpose I/O block for 1 to 32 pins on a simple 32-bit register bus (address, write strobe, write data, combinational read data). Every pin has a direction bit and an output bit. Pins configured as outputs are driven from the output register. Reading the value register shows the live input state for input pins and the driven value for output pins.

Every pin also feeds an interrupt detector. The detector is fed through a two-flop synchroniser, and its trigger type is chosen per pin by three register bits: an edge/level select, a polarity bit and a both-edges bit. A detection sets a per-pin raw status bit. Software clears that bit by writing a 1 to the matching position of a write-only clear register. The raw status, masked by a per-pin enable, forms the pending word, and the OR of the pending word drives a single interrupt line. A constant version register tells software that the both-edges register is present.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable register (0x08) is 0, the output register (0x00 write side) is 0, the direction register (0x04) has every implemented bit at 1, and `irq_o` is low.
- R2: A direction bit of 1 makes the pin an input (`pin_oe_o` bit 0). A direction bit of 0 makes it an output (`pin_oe_o` bit 1) driven from the output register on `pin_o`. A read of 0x00 returns the synchronised `pin_i` bit for input pins and the output register bit for output pins.
- R3: With the edge/level bit (0x18) at 0 and the both-edges bit (0x24) at 0, the pin is level triggered. Polarity (0x1C) 1 means active high and 0 means active low. The raw status bit (read at 0x0C) is set while the level is active.
- R4: With the edge/level bit at 1 and the both-edges bit at 0, the pin is edge triggered. Polarity 1 selects rising edges and 0 selects falling edges, and the opposite edge sets nothing.
- R5: With the both-edges bit at 1, both rising and falling edges set the raw status bit, whatever the polarity bit holds.
- R6: Writing 1 to a bit of the clear register (0x14) clears that raw status bit, and writing 0 leaves it unchanged. An edge-set bit stays set until it is cleared, and a level source whose level is still active sets its bit again at once.
- R7: A read of 0x10 returns the raw status ANDed with the enable register, and `irq_o` is the OR of those pending bits.
- R8: A read of 0x20 returns the constant 3.
- R9: If a detection and a clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_i | input | NPINS | Pin input levels (asynchronous) |
| pin_o | output | NPINS | Pin output values |
| pin_oe_o | output | NPINS | Pin output enables (1 = driving) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that a set status bit holds until a clear names it, that a cleared bit drops unless a detection coincides with the clear, that a detection always wins over a clear, that the output enables follow a direction write, and that the interrupt stays low while the enable word is zero. Only the bench scenarios show that each trigger mode reacts to the right pin transitions and ignores the wrong ones: active-high and active-low levels, single rising and falling edges, and both edges. The bench scenarios also show the pending masking and the mixed value read-back.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFF_VAL  = 'h00;
  localparam int unsigned OFF_DIR  = 'h04;
  localparam int unsigned OFF_EN   = 'h08;
  localparam int unsigned OFF_RAW  = 'h0C;
  localparam int unsigned OFF_PEND = 'h10;
  localparam int unsigned OFF_CLR  = 'h14;
  localparam int unsigned OFF_EDGE = 'h18;
  localparam int unsigned OFF_POL  = 'h1C;
  localparam int unsigned OFF_VER  = 'h20;
  localparam int unsigned OFF_BOTH = 'h24;
  localparam logic [31:0] VERSION  = 32'd3;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] edge_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] both_i,
  output logic [NPINS-1:0] hit_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= sync_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall;
    assign rise = sync_i[i] & ~prev_q[i];
    assign fall = ~sync_i[i] & prev_q[i];
    always_comb begin
      if (both_i[i])      hit_o[i] = rise | fall;
      else if (edge_i[i]) hit_o[i] = pol_i[i] ? rise : fall;
      else                hit_o[i] = pol_i[i] ? sync_i[i] : ~sync_i[i];
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] hit_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] raw_o
);
  // new event has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else raw_o <= hit_i | (raw_o & ~clr_i);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] out_q, dir_q, en_q, edge_q, pol_q, both_q;
  logic [NPINS-1:0] sync, hit, raw, clr, pend, val;
  logic [NPINS-1:0] wd;

  assign wd = wdata_i[NPINS-1:0];

  function automatic logic wr_at(input int unsigned off);
    return we_i && (addr_i == ADDR_W'(off));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '1;
      en_q   <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else begin
      if (wr_at(OFF_VAL))  out_q  <= wd;
      if (wr_at(OFF_DIR))  dir_q  <= wd;
      if (wr_at(OFF_EN))   en_q   <= wd;
      if (wr_at(OFF_EDGE)) edge_q <= wd;
      if (wr_at(OFF_POL))  pol_q  <= wd;
      if (wr_at(OFF_BOTH)) both_q <= wd;
    end
  end

  assign clr = wr_at(OFF_CLR) ? wd : '0;

  gpio_irq_sync #(.W(NPINS), .STAGES(2)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync)
  );

  gpio_irq_trig #(.NPINS(NPINS)) i_trig (
    .clk_i, .rst_ni, .sync_i(sync), .edge_i(edge_q), .pol_i(pol_q),
    .both_i(both_q), .hit_o(hit)
  );

  gpio_irq_status #(.NPINS(NPINS)) i_status (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(clr), .raw_o(raw)
  );

  assign pend     = raw & en_q;
  assign irq_o    = |pend;
  assign pin_o    = out_q;
  assign pin_oe_o = ~dir_q;
  assign val      = (sync & dir_q) | (out_q & ~dir_q);

  always_comb begin
    rdata_o = '0;
    unique case (32'(addr_i))
      OFF_VAL:  rdata_o = 32'(val);
      OFF_DIR:  rdata_o = 32'(dir_q);
      OFF_EN:   rdata_o = 32'(en_q);
      OFF_RAW:  rdata_o = 32'(raw);
      OFF_PEND: rdata_o = 32'(pend);
      OFF_EDGE: rdata_o = 32'(edge_q);
      OFF_POL:  rdata_o = 32'(pol_q);
      OFF_VER:  rdata_o = VERSION;
      OFF_BOTH: rdata_o = 32'(both_q);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NPINS-1:0]  pin_oe_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  raw,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  en
);
  logic [NPINS-1:0] clr_mask;
  assign clr_mask = (we_i && addr_i == ADDR_W'(OFF_CLR)) ? wdata_i[NPINS-1:0] : '0;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw & $past(raw & ~clr_mask)) == $past(raw & ~clr_mask)));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw & $past(clr_mask & ~hit)) == '0));

  assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit) & ~raw) == '0));

  assert_oe_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_DIR)) |=> (pin_oe_o == ~$past(wdata_i[NPINS-1:0])));

  assert_no_irq_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);

  assert_version_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_VER)) |-> (rdata_o == VERSION));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o),
  .raw(raw), .hit(hit), .en(en_q)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned NPINS = 8;
  localparam int unsigned ADDR_W = 6;

  localparam int K_RD = 0, K_IRQ = 1, K_PIN = 2, K_OE = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic              clk_i = 0;
  logic              rst_ni = 0;
  logic              we_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NPINS-1:0]  pin_i = '0;
  logic [NPINS-1:0]  pin_o, pin_oe_o;
  logic              irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_irq_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_gpio_irq_ctrl (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .irq_o
  );

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = rdata_o;
          K_IRQ:   act = 32'(irq_o);
          K_PIN:   act = 32'(pin_o);
          default: act = 32'(pin_oe_o);
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_at(input int kind, input logic [5:0] a, input logic [31:0] e,
                           input string tag);
    item_t it;
    @(posedge clk_i); #1;
    addr_i = ADDR_W'(a);
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    we_i = 1; addr_i = ADDR_W'(a); wdata_i = d;
    @(posedge clk_i); #1;
    we_i = 0;
  endtask

  task automatic pins(input logic [NPINS-1:0] v);
    @(posedge clk_i); #1;
    pin_i = v;
    repeat (3) @(posedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    repeat (3) @(posedge clk_i);
    // R1 reset state
    expect_at(K_RD, 6'h04, 32'h0000_00FF, "R1 dir reset");
    expect_at(K_RD, 6'h08, 32'h0, "R1 enable reset");
    expect_at(K_PIN, 6'h00, 32'h0, "R1 output reset");
    expect_at(K_IRQ, 6'h00, 32'h0, "R1 irq reset");
    expect_at(K_RD, 6'h20, 32'd3, "R8 version");
    expect_at(K_RD, 6'h0C, 32'h0000_00FF, "R3 active-low level on low pins");
    expect_at(K_RD, 6'h10, 32'h0, "R7 pending masked after reset");

    wr(6'h1C, 32'hFF);
    wr(6'h14, 32'hFF);
    expect_at(K_RD, 6'h0C, 32'h0, "R6 clear all");

    pins(8'h01);
    expect_at(K_RD, 6'h0C, 32'h01, "R3 active-high level");
    wr(6'h14, 32'h01);
    expect_at(K_RD, 6'h0C, 32'h01, "R6 R9 level still active re-sets");
    pins(8'h00);
    expect_at(K_RD, 6'h0C, 32'h01, "R6 status latched after level gone");
    wr(6'h14, 32'h01);
    expect_at(K_RD, 6'h0C, 32'h00, "R6 clear after level gone");

    wr(6'h18, 32'h0E);
    wr(6'h1C, 32'hFB);
    wr(6'h24, 32'h08);
    expect_at(K_RD, 6'h0C, 32'h00, "R4 mode change sets nothing");
    pins(8'h02);
    expect_at(K_RD, 6'h0C, 32'h02, "R4 rising edge");
    wr(6'h14, 32'h00);
    expect_at(K_RD, 6'h0C, 32'h02, "R6 clear write of 0 no effect");
    wr(6'h14, 32'h02);
    expect_at(K_RD, 6'h0C, 32'h00, "R4 edge does not re-set while high");
    pins(8'h06);
    expect_at(K_RD, 6'h0C, 32'h00, "R4 rise ignored in falling mode");
    pins(8'h02);
    expect_at(K_RD, 6'h0C, 32'h04, "R4 falling edge");
    wr(6'h14, 32'h04);
    pins(8'h0A);
    expect_at(K_RD, 6'h0C, 32'h08, "R5 both-edges rise");
    wr(6'h14, 32'h08);
    pins(8'h02);
    expect_at(K_RD, 6'h0C, 32'h08, "R5 both-edges fall");
    wr(6'h14, 32'h08);

    wr(6'h08, 32'h08);
    expect_at(K_IRQ, 6'h00, 32'h0, "R7 irq low with no status");
    pins(8'h0A);
    pins(8'h08);
    pins(8'h0A);
    expect_at(K_RD, 6'h0C, 32'h0A, "R7 raw includes disabled pin");
    expect_at(K_RD, 6'h10, 32'h08, "R7 pending masked by enable");
    expect_at(K_IRQ, 6'h00, 32'h1, "R7 irq raised");
    wr(6'h14, 32'h08);
    expect_at(K_IRQ, 6'h00, 32'h0, "R7 irq drops after clear");
    expect_at(K_RD, 6'h10, 32'h0, "R7 pending empty");

    wr(6'h04, 32'hF0);
    expect_at(K_OE, 6'h00, 32'h0F, "R2 output enables");
    wr(6'h00, 32'h05);
    expect_at(K_PIN, 6'h00, 32'h05, "R2 pin outputs");
    pins(8'h3A);
    expect_at(K_RD, 6'h00, 32'h35, "R2 mixed value read");

    repeat (2) @(posedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule